// File: doc/BRIEF.md
# Stereo Channel and Master Volume Controller

This block applies digital gain to a stereo stream of 18-bit signed samples. Each channel has its own volume code, and a shared master code is added to it. Both codes are in half-decibel units: code zero is the loudest setting, +36 dB, and every code step lowers the level by 0.5 dB. The summed code is split into whole 6 dB octaves and a half-decibel remainder. The remainder selects a mantissa from a twelve-entry table, and the octave count sets an arithmetic right shift. The scaled result saturates instead of wrapping. A summed code at or above a silence threshold gives zero output.

A mute input forces both outputs to zero but still lets the output strobe pulse. With soft volume off, a new setting takes effect at once. With soft volume on, each channel's working code walks toward its new target by one half-decibel step per ramp tick. A ramp tick occurs on every (ramp_sel+1)-th input sample. The block produces one registered result per input strobe.

Top module: `vol_ctrl`

## Requirements
- R1: For a working code c (with c below the silence threshold), the output is the saturated value of floor(x * M / 2^(q+9)), where q = c / 12, r = c mod 12, and M = round(32768 * 2^(-r/12)). A non-negative input never gives a negative output.
- R2: After reset, out_valid, out_l and out_r are 0. Each working code starts at 72, which is unity gain, so with both volume inputs at 72 and master at 0 a sample passes unchanged.
- R3: Results above 131071 are clamped to 131071, and results below -131072 are clamped to -131072.
- R4: A working code of 240 (SILENCE_CODE) or more yields 0. Code 239 still follows R1.
- R5: While mute is 1, a strobed sample produces out_valid = 1 with out_l = out_r = 0.
- R6: With soft_en = 0, each channel's working code equals its volume input plus vol_master. A register change applies to any sample strobed two or more cycles later.
- R7: With soft_en = 1, a tick happens on the strobe that completes each run of ramp_sel+1 samples. On a tick, each working code moves by one toward its target. A sample strobed on a tick is scaled with the code from before that step.
- R8: In soft mode, a working code that has reached its target stays there and does not overshoot.
- R9: out_valid is 1 exactly one cycle after in_valid. Outputs keep their values between strobes.
- R10: The left and right channels use their own volume codes, and vol_master adds to both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_l | input | 18 | Left sample, signed |
| in_r | input | 18 | Right sample, signed |
| vol_l | input | 8 | Left volume code, 0.5 dB per step from +36 dB |
| vol_r | input | 8 | Right volume code |
| vol_master | input | 8 | Master offset code added to both channels |
| mute | input | 1 | Forces outputs to zero |
| soft_en | input | 1 | Selects ramped gain changes |
| ramp_sel | input | 4 | Ramp pacing: one tick per ramp_sel+1 samples |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_l | output | 18 | Scaled left sample |
| out_r | output | 18 | Scaled right sample |

## Verification
In soft mode, a ramp tick and the scaling of a sample fall on the same input strobe. The bench provokes this by changing the targets and then streaming samples with ramp_sel at 1 and at 0. For each sample it predicts the code in force from the number of strobes already seen, and expects the pre-step code. A mute that coincides with an ongoing ramp is also possible. The bench judges this through R5's zero output while the strobe still pulses.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int UNITY_CODE   = 72;  // working code for 0 dB
  localparam int CODES_PER_OCT = 12; // half-dB codes per 6 dB
  localparam int BASE_SHIFT   = 9;   // 15 mantissa bits minus 6 octaves of headroom

  // Q1.15 mantissa for 2^(-idx/12), idx in 0..11
  function automatic logic [15:0] frac_mant(input int idx);
    case (idx)
      0:       frac_mant = 16'd32768;
      1:       frac_mant = 16'd30929;
      2:       frac_mant = 16'd29193;
      3:       frac_mant = 16'd27554;
      4:       frac_mant = 16'd26008;
      5:       frac_mant = 16'd24548;
      6:       frac_mant = 16'd23170;
      7:       frac_mant = 16'd21870;
      8:       frac_mant = 16'd20643;
      9:       frac_mant = 16'd19484;
      10:      frac_mant = 16'd18390;
      default: frac_mant = 16'd17358;
    endcase
  endfunction
endpackage

// File: rtl/vol_ramp.sv
module vol_ramp #(
  parameter int SW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_en,
  input  logic          tick,
  input  logic [SW-1:0] target,
  output logic [SW-1:0] cur
);
  logic need_up, need_dn;
  assign need_up = cur < target;
  assign need_dn = cur > target;

  always_ff @(posedge clk) begin
    if (!rst_n)                cur <= SW'(vol_pkg::UNITY_CODE);
    else if (!soft_en)         cur <= target;
    else if (tick && need_up)  cur <= cur + SW'(1);
    else if (tick && need_dn)  cur <= cur - SW'(1);
  end

  // R7: soft-mode code moves at most one step per cycle, and only on a tick
  assert_ramp_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_en |=> (cur == $past(cur) || cur == $past(cur) + SW'(1) || cur == $past(cur) - SW'(1)));
  assert_ramp_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_en && !tick) |=> $stable(cur));
  // R8: code parked at its target does not move
  assert_ramp_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_en && cur == target) |=> $stable(cur));
endmodule

// File: rtl/vol_scale.sv
module vol_scale #(
  parameter int DW      = 18,
  parameter int SW      = 9,
  parameter int SILENCE = 240
) (
  input  logic signed [DW-1:0] x,
  input  logic        [SW-1:0] code,
  output logic signed [DW-1:0] y
);
  localparam int PW = DW + 17;
  localparam logic [SW-1:0] OCT = SW'(vol_pkg::CODES_PER_OCT);
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  function automatic logic signed [DW-1:0] apply_gain(input logic signed [DW-1:0] s,
                                                      input logic [SW-1:0] c);
    logic [SW-1:0]          q, r;
    logic signed [16:0]     mant;
    logic signed [PW-1:0]   prod, shifted;
    q       = c / OCT;
    r       = c % OCT;
    mant    = signed'({1'b0, vol_pkg::frac_mant(int'(r))});
    prod    = PW'(s) * PW'(mant);
    shifted = prod >>> (q + SW'(vol_pkg::BASE_SHIFT));
    if (c >= SW'(SILENCE))   apply_gain = '0;
    else if (shifted > MAXV) apply_gain = MAXV[DW-1:0];
    else if (shifted < MINV) apply_gain = MINV[DW-1:0];
    else                     apply_gain = shifted[DW-1:0];
  endfunction

  assign y = apply_gain(x, code);
endmodule

// File: rtl/vol_ctrl.sv
module vol_ctrl #(
  parameter int DW      = 18,
  parameter int CW      = 8,
  parameter int RW      = 4,
  parameter int SILENCE = 240
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  input  logic [CW-1:0]        vol_l,
  input  logic [CW-1:0]        vol_r,
  input  logic [CW-1:0]        vol_master,
  input  logic                 mute,
  input  logic                 soft_en,
  input  logic [RW-1:0]        ramp_sel,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r
);
  localparam int SW = CW + 1;
  localparam int CH = 2;

  logic signed [DW-1:0] smp_in  [CH];
  logic signed [DW-1:0] smp_out [CH];
  logic [CW-1:0]        ch_vol  [CH];
  logic [SW-1:0]        tgt_code [CH];
  logic [SW-1:0]        cur_code [CH];
  logic [RW-1:0]        div_cnt;
  logic                 ramp_tick;

  assign smp_in[0] = in_l;
  assign smp_in[1] = in_r;
  assign ch_vol[0] = vol_l;
  assign ch_vol[1] = vol_r;

  // ramp pacing: one tick per ramp_sel+1 strobes
  assign ramp_tick = soft_en && in_valid && (div_cnt == ramp_sel);

  always_ff @(posedge clk) begin
    if (!rst_n || !soft_en) div_cnt <= '0;
    else if (in_valid)      div_cnt <= ramp_tick ? '0 : div_cnt + RW'(1);
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    assign tgt_code[i] = {1'b0, ch_vol[i]} + {1'b0, vol_master};

    vol_ramp #(.SW(SW)) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_en (soft_en),
      .tick    (ramp_tick),
      .target  (tgt_code[i]),
      .cur     (cur_code[i])
    );

    vol_scale #(.DW(DW), .SW(SW), .SILENCE(SILENCE)) u_scale (
      .x    (smp_in[i]),
      .code (cur_code[i]),
      .y    (smp_out[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_l <= mute ? '0 : smp_out[0];
        out_r <= mute ? '0 : smp_out[1];
      end
    end
  end

  // R5: muted strobe yields silence on both channels
  assert_mute_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mute) |=> (out_l == '0 && out_r == '0));
  // R9: no strobe, no change on the outputs
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_l) && $stable(out_r) && !out_valid));
  // R4: code past the threshold silences the channel
  assert_silence_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cur_code[0] >= SW'(SILENCE)) |=> out_l == '0);
  // R1: gain never flips polarity
  assert_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_r >= 0) |=> out_r >= 0);
endmodule

// File: tb/vol_ctrl_test.sv
`timescale 1ns/1ps
module vol_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [17:0] in_l = '0, in_r = '0;
  logic [7:0] vol_l = 8'd72, vol_r = 8'd72, vol_master = 8'd0;
  logic mute = 1'b0, soft_en = 1'b0;
  logic [3:0] ramp_sel = '0;
  logic out_valid;
  logic signed [17:0] out_l, out_r;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  vol_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
    .vol_l(vol_l), .vol_r(vol_r), .vol_master(vol_master), .mute(mute),
    .soft_en(soft_en), .ramp_sel(ramp_sel),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
  );

  function automatic int model(input int x, input int code);
    int q, r, m;
    longint p;
    if (code >= 240) return 0;
    q = code / 12;
    r = code % 12;
    m = int'($floor((2.0 ** (-real'(r) / 12.0)) * 32768.0 + 0.5));
    p = longint'(x) * longint'(m);
    p = p >>> (q + 9);
    if (p > 131071) p = 131071;
    if (p < -131072) p = -131072;
    return int'(p);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic send(input string req, input int xl, input int xr, input int el, input int er);
    @(negedge clk);
    in_l = 18'(xl); in_r = 18'(xr); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " left"}, int'(out_l), el);
    check({req, " right"}, int'(out_r), er);
  endtask

  task automatic set_regs(input int l, input int r, input int m);
    @(negedge clk);
    vol_l = 8'(l); vol_r = 8'(r); vol_master = 8'(m);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R2 valid", int'(out_valid), 0);
    check("R2 left", int'(out_l), 0);
    check("R2 right", int'(out_r), 0);
    send("R2 unity", 12345, -54321, 12345, -54321);
  endtask

  task automatic t_codes;
    set_regs(0, 10, 24);   // left +24 dB, right +19 dB
    send("R10 master", 1000, -1000, model(1000, 24), model(-1000, 34));
    check("R1 plus24", model(1000, 24), 16000);
    set_regs(100, 73, 5);
    send("R1 mixed", 99999, 99999, model(99999, 105), model(99999, 78));
    set_regs(72, 85, 0);
    send("R10 indep", -77777, -77777, -77777, model(-77777, 85));
  endtask

  task automatic t_sat;
    set_regs(0, 0, 0);
    send("R3 clamp", 5000, -5000, 131071, -131072);
  endtask

  task automatic t_silence;
    set_regs(200, 150, 90);
    send("R4 deep", 131071, -131072, 0, 0);
    set_regs(239, 240, 0);
    send("R4 edge", 131071, 131071, model(131071, 239), 0);
    check("R4 edge nonzero", int'(model(131071, 239) != 0), 1);
  endtask

  task automatic t_mute;
    set_regs(72, 72, 0);
    @(negedge clk) mute = 1'b1;
    send("R5 mute", 4444, -4444, 0, 0);
    @(negedge clk) mute = 1'b0;
    send("R5 unmute", 4444, -4444, 4444, -4444);
  endtask

  task automatic t_hold;
    send("R9 base", 300, 400, 300, 400);
    @(negedge clk);
    in_l = 18'(9); in_r = 18'(9);
    repeat (3) @(negedge clk);
    check("R9 idle valid", int'(out_valid), 0);
    check("R9 idle left", int'(out_l), 300);
    check("R9 idle right", int'(out_r), 400);
  endtask

  task automatic t_hard;
    set_regs(72, 72, 0);
    @(negedge clk);
    vol_l = 8'd96; vol_r = 8'd48;
    @(negedge clk);
    send("R6 apply", 20000, 20000, model(20000, 96), model(20000, 48));
  endtask

  task automatic t_soft;
    set_regs(72, 72, 0);
    @(negedge clk);
    soft_en = 1'b1; ramp_sel = 4'd1;
    vol_l = 8'd76; vol_r = 8'd70;
    @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      int st = k / 2;
      int cl = 72 + ((st < 4) ? st : 4);
      int cr = 72 - ((st < 2) ? st : 2);
      send((k < 8) ? "R7 ramp" : "R8 park", 100000, 100000, model(100000, cl), model(100000, cr));
    end
    @(negedge clk);
    ramp_sel = 4'd0; vol_l = 8'd72; vol_r = 8'd70;
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      int cl = 76 - ((k < 4) ? k : 4);
      send((k < 4) ? "R7 fast" : "R8 fast park", -90000, -90000, model(-90000, cl), model(-90000, 70));
    end
    @(negedge clk) soft_en = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog got=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_codes();
    t_sat();
    t_silence();
    t_mute();
    t_hold();
    t_hard();
    t_soft();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule